// File: doc/BRIEF.md
# Interlaced Video Sync Generator with External Resynchronization

The block derives the timing of a 525-line interlaced video raster from a single pixel-rate clock. A horizontal counter runs through 780 clock positions per line, and position 390 marks the half line. A line counter runs through 525 lines per frame. The frame holds two fields, odd and even. The even field begins at the half line of the middle line. From these two counters a combinational decoder produces these outputs:

- horizontal drive
- vertical drive
- composite sync, with equalizing and serrated vertical pulses
- composite blanking
- the field flag
- a pulse at twice the line rate

Two active-low reset inputs let the raster follow an external reference. A falling edge on the horizontal input restarts the line. In continuous mode, later edges that land close to the running line start are treated as jitter and absorbed. A falling edge on the vertical input is first classified as odd or even by where it falls within the line. It then schedules a field start, either after a fixed 259-line delay (continuous mode) or at the next matching boundary (direct mode). In direct mode a second control input selects whether the horizontal input is honoured or ignored.

Top module: `vsync_gen`

## Requirements
- R1: After reset the horizontal position is 0 and advances by one per clock, wrapping from 779 to 0. `hd_n` is low exactly at positions 0 to 77. The line advances whenever the position becomes 0, wrapping from 524 to 0.
- R2: `blank` is high at positions below 132 and throughout the first 40 half lines of each field.
- R3: `csync_n` is low as follows:
  - In half lines 0 to 5 and 12 to 17 of a field, it is low for the first 30 clocks of each half line.
  - In half lines 6 to 11, it is low for the first 330 clocks of each half line.
  - Elsewhere, it is low at positions 0 to 59 of the line.
- R4: The half-line index is twice the line number, plus one at positions of 390 and above. The field is odd (`field`=0) below index 525 and even (`field`=1) from 525 on. `vd_n` is low during the first 18 half lines of each field. Reset starts in the odd field at index 0.
- R5: `fh2` is high exactly at positions 0 and 390.
- R6: In continuous mode (`direct_mode`=0), the first `hrst_n` falling edge after reset makes the position 0 in the following clock.
- R7: In continuous mode, after that first edge, a later falling edge resets the position only when the position it would otherwise have next is more than 2 away from 0 around the line. Otherwise the edge is ignored.
- R8: In direct mode (`direct_mode`=1), every `hrst_n` falling edge resets the position when `direct_hv`=1, and every such edge is ignored when `direct_hv`=0.
- R9: A `vrst_n` falling edge is classified as odd when the position in that clock is below 390, and as even otherwise.
- R10: In continuous mode, an odd edge loads line 0 at the 259th line start after the edge. An even edge loads line 262 at the first half-line boundary after that 259th line start.
- R11: In direct mode, an odd edge loads line 0 at the next line start. An even edge loads line 262 at the next half-line boundary.
- R12: When `hrst_n` and `vrst_n` fall in the same clock, the vertical edge is classified using the position before the horizontal reset. A new `vrst_n` edge replaces any field start still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| hrst_n | input | 1 | External horizontal reset, falling edge active |
| vrst_n | input | 1 | External vertical reset, falling edge active |
| direct_mode | input | 1 | 0 continuous reset mode, 1 direct reset mode |
| direct_hv | input | 1 | In direct mode: 1 honour `hrst_n`, 0 ignore it |
| hd_n | output | 1 | Horizontal drive, active low |
| vd_n | output | 1 | Vertical drive, active low |
| csync_n | output | 1 | Composite sync, active low |
| blank | output | 1 | Composite blanking, active high |
| field | output | 1 | 0 odd field, 1 even field |
| fh2 | output | 1 | One-clock pulse at twice the line rate |

## Verification
Two functions can fall in the same cycle: the horizontal counter being forced to zero, and the vertical edge being classified from that counter. The bench drives both reset inputs low on the same clock, at a position in the second half of the line. The correct outcome is an even-field start exactly one half line after the forced line start. Classifying the edge after the horizontal reset would instead give an odd start one full line later. A behavioural model, built from queues of integers, is compared with every output on every clock. Directed checks sample the drive outputs at the computed landing cycle.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int unsigned DEF_H_TOTAL    = 780;
    localparam int unsigned DEF_HALF       = 390;
    localparam int unsigned DEF_LINES      = 525;
    localparam int unsigned DEF_HD_LOW     = 78;
    localparam int unsigned DEF_HBLK       = 132;
    localparam int unsigned DEF_HSYNC      = 60;
    localparam int unsigned DEF_EQ_W       = 30;
    localparam int unsigned DEF_VS_W       = 330;
    localparam int unsigned DEF_VD_LINES   = 9;
    localparam int unsigned DEF_VBLK_LINES = 20;
    localparam int unsigned DEF_V_DELAY    = 259;
    localparam int unsigned DEF_JITTER     = 2;

    typedef enum logic [1:0] {
        VP_IDLE  = 2'd0,
        VP_COUNT = 2'd1,
        VP_MID   = 2'd2
    } vpend_e;

    typedef struct packed {
        logic wrap;
        logic mid;
        logic hreset;
    } hevt_t;

    typedef struct packed {
        logic hd_n;
        logic vd_n;
        logic csync_n;
        logic blank;
        logic field;
        logic fh2;
    } sync_out_t;

    function automatic int unsigned ring_dist(input int unsigned pos, input int unsigned total);
        return (pos <= total / 2) ? pos : total - pos;
    endfunction

endpackage

// File: rtl/vsg_hcount.sv
module vsg_hcount
    import vsg_pkg::*;
#(
    parameter int unsigned H_TOTAL = DEF_H_TOTAL,
    parameter int unsigned HALF    = DEF_HALF,
    parameter int unsigned JITTER  = DEF_JITTER,
    localparam int unsigned HW     = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hrst_n,
    input  logic          direct_mode,
    input  logic          direct_hv,
    output logic [HW-1:0] hcnt,
    output hevt_t         hev
);

    logic          hrst_q;
    logic          locked;
    logic          fall;
    logic          take;
    logic [HW-1:0] nom;
    logic [HW-1:0] nxt;

    always_comb begin
        fall = hrst_q & ~hrst_n;
        nom  = (hcnt == HW'(H_TOTAL - 1)) ? '0 : hcnt + 1'b1;
        if (direct_mode) begin
            take = fall & direct_hv;
        end else begin
            take = fall & (~locked | (ring_dist(32'(nom), H_TOTAL) > JITTER));
        end
        nxt        = take ? '0 : nom;
        hev.hreset = take;
        hev.wrap   = (nxt == '0);
        hev.mid    = (nxt == HW'(HALF));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt   <= '0;
            hrst_q <= 1'b1;
            locked <= 1'b0;
        end else begin
            hcnt   <= nxt;
            hrst_q <= hrst_n;
            if (fall && !direct_mode) begin
                locked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount
    import vsg_pkg::*;
#(
    parameter int unsigned H_TOTAL = DEF_H_TOTAL,
    parameter int unsigned HALF    = DEF_HALF,
    parameter int unsigned LINES   = DEF_LINES,
    parameter int unsigned V_DELAY = DEF_V_DELAY,
    localparam int unsigned HW     = $clog2(H_TOTAL),
    localparam int unsigned LW     = $clog2(LINES),
    localparam int unsigned DW     = $clog2(V_DELAY + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vrst_n,
    input  logic          direct_mode,
    input  logic [HW-1:0] hcnt,
    input  logic          h_wrap,
    input  logic          h_mid,
    output logic [LW-1:0] line
);

    localparam logic [LW-1:0] EVEN_LINE = LW'((LINES - 1) / 2);

    logic          vrst_q;
    logic          fall;
    logic          is_even;
    vpend_e        st, st_n;
    logic [DW-1:0] cnt, cnt_n;
    logic          even_q, even_n;
    logic [LW-1:0] line_n;

    always_comb begin
        fall    = vrst_q & ~vrst_n;
        is_even = (hcnt >= HW'(HALF));
        st_n    = st;
        cnt_n   = cnt;
        even_n  = even_q;
        if (h_wrap) begin
            line_n = (line == LW'(LINES - 1)) ? '0 : line + 1'b1;
        end else begin
            line_n = line;
        end
        if (fall) begin
            even_n = is_even;
            if (direct_mode && is_even) begin
                st_n = VP_MID;
            end else begin
                st_n  = VP_COUNT;
                cnt_n = direct_mode ? DW'(1) : DW'(V_DELAY);
            end
        end else begin
            case (st)
                VP_COUNT: begin
                    if (h_wrap) begin
                        if (cnt == DW'(1)) begin
                            if (even_q) begin
                                st_n = VP_MID;
                            end else begin
                                line_n = '0;
                                st_n   = VP_IDLE;
                            end
                        end else begin
                            cnt_n = cnt - 1'b1;
                        end
                    end
                end
                VP_MID: begin
                    if (h_mid) begin
                        line_n = EVEN_LINE;
                        st_n   = VP_IDLE;
                    end
                end
                default: st_n = VP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line   <= '0;
            vrst_q <= 1'b1;
            st     <= VP_IDLE;
            cnt    <= '0;
            even_q <= 1'b0;
        end else begin
            line   <= line_n;
            vrst_q <= vrst_n;
            st     <= st_n;
            cnt    <= cnt_n;
            even_q <= even_n;
        end
    end

endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
    import vsg_pkg::*;
#(
    parameter int unsigned H_TOTAL    = DEF_H_TOTAL,
    parameter int unsigned HALF       = DEF_HALF,
    parameter int unsigned LINES      = DEF_LINES,
    parameter int unsigned HD_LOW     = DEF_HD_LOW,
    parameter int unsigned HBLK       = DEF_HBLK,
    parameter int unsigned HSYNC      = DEF_HSYNC,
    parameter int unsigned EQ_W       = DEF_EQ_W,
    parameter int unsigned VS_W       = DEF_VS_W,
    parameter int unsigned VD_LINES   = DEF_VD_LINES,
    parameter int unsigned VBLK_LINES = DEF_VBLK_LINES,
    localparam int unsigned HW        = $clog2(H_TOTAL),
    localparam int unsigned LW        = $clog2(LINES)
) (
    input  logic [HW-1:0] hcnt,
    input  logic [LW-1:0] line,
    output sync_out_t     so
);

    localparam int unsigned VD_HL   = 2 * VD_LINES;
    localparam int unsigned EQ_HL   = VD_HL / 3;
    localparam int unsigned VBLK_HL = 2 * VBLK_LINES;

    int unsigned h, hl, rel, ph;
    logic        odd_half, in_eq, in_vs, sync_lo;

    always_comb begin
        h        = 32'(hcnt);
        odd_half = (h >= HALF);
        hl       = 2 * 32'(line) + (odd_half ? 1 : 0);
        so.field = (hl >= LINES);
        rel      = so.field ? hl - LINES : hl;
        ph       = odd_half ? h - HALF : h;
        in_eq    = (rel < EQ_HL) || ((rel >= 2 * EQ_HL) && (rel < 3 * EQ_HL));
        in_vs    = (rel >= EQ_HL) && (rel < 2 * EQ_HL);
        if (in_eq) begin
            sync_lo = (ph < EQ_W);
        end else if (in_vs) begin
            sync_lo = (ph < VS_W);
        end else begin
            sync_lo = (h < HSYNC);
        end
        so.hd_n    = (h >= HD_LOW);
        so.vd_n    = (rel >= VD_HL);
        so.csync_n = ~sync_lo;
        so.blank   = (h < HBLK) || (rel < VBLK_HL);
        so.fh2     = (h == 0) || (h == HALF);
    end

endmodule

// File: rtl/vsync_gen.sv
module vsync_gen
    import vsg_pkg::*;
#(
    parameter int unsigned H_TOTAL    = DEF_H_TOTAL,
    parameter int unsigned HALF       = DEF_HALF,
    parameter int unsigned LINES      = DEF_LINES,
    parameter int unsigned HD_LOW     = DEF_HD_LOW,
    parameter int unsigned HBLK       = DEF_HBLK,
    parameter int unsigned HSYNC      = DEF_HSYNC,
    parameter int unsigned EQ_W       = DEF_EQ_W,
    parameter int unsigned VS_W       = DEF_VS_W,
    parameter int unsigned VD_LINES   = DEF_VD_LINES,
    parameter int unsigned VBLK_LINES = DEF_VBLK_LINES,
    parameter int unsigned V_DELAY    = DEF_V_DELAY,
    parameter int unsigned JITTER     = DEF_JITTER
) (
    input  logic clk,
    input  logic rst,
    input  logic hrst_n,
    input  logic vrst_n,
    input  logic direct_mode,
    input  logic direct_hv,
    output logic hd_n,
    output logic vd_n,
    output logic csync_n,
    output logic blank,
    output logic field,
    output logic fh2
);

    localparam int unsigned HW = $clog2(H_TOTAL);
    localparam int unsigned LW = $clog2(LINES);

    logic [HW-1:0] hcnt;
    logic [LW-1:0] line;
    hevt_t         hev;
    sync_out_t     so;
    logic          h_reset;

    vsg_hcount #(
        .H_TOTAL(H_TOTAL), .HALF(HALF), .JITTER(JITTER)
    ) u_hcount (
        .clk(clk), .rst(rst), .hrst_n(hrst_n),
        .direct_mode(direct_mode), .direct_hv(direct_hv),
        .hcnt(hcnt), .hev(hev)
    );

    vsg_vcount #(
        .H_TOTAL(H_TOTAL), .HALF(HALF), .LINES(LINES), .V_DELAY(V_DELAY)
    ) u_vcount (
        .clk(clk), .rst(rst), .vrst_n(vrst_n), .direct_mode(direct_mode),
        .hcnt(hcnt), .h_wrap(hev.wrap), .h_mid(hev.mid), .line(line)
    );

    vsg_decode #(
        .H_TOTAL(H_TOTAL), .HALF(HALF), .LINES(LINES), .HD_LOW(HD_LOW),
        .HBLK(HBLK), .HSYNC(HSYNC), .EQ_W(EQ_W), .VS_W(VS_W),
        .VD_LINES(VD_LINES), .VBLK_LINES(VBLK_LINES)
    ) u_decode (
        .hcnt(hcnt), .line(line), .so(so)
    );

    assign h_reset = hev.hreset;
    assign hd_n    = so.hd_n;
    assign vd_n    = so.vd_n;
    assign csync_n = so.csync_n;
    assign blank   = so.blank;
    assign field   = so.field;
    assign fh2     = so.fh2;

endmodule

// File: rtl/vsync_gen_chk.sv
module vsync_gen_chk #(
    parameter int unsigned H_TOTAL = 780,
    parameter int unsigned HALF    = 390,
    localparam int unsigned HW     = $clog2(H_TOTAL)
) (
    input logic          clk,
    input logic          rst,
    input logic          hd_n,
    input logic          vd_n,
    input logic          blank,
    input logic          field,
    input logic          fh2,
    input logic [HW-1:0] hcnt,
    input logic          h_reset
);

    p_hcnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        hcnt < HW'(H_TOTAL));

    p_hd_in_blank_r2: assert property (@(posedge clk) disable iff (rst)
        !hd_n |-> blank);

    p_vd_in_blank_r4: assert property (@(posedge clk) disable iff (rst)
        !vd_n |-> blank);

    p_field_flip_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(field) |-> !vd_n);

    p_fh2_single_r5: assert property (@(posedge clk) disable iff (rst)
        (fh2 && !h_reset) |=> !fh2);

    p_vd_fall_edge_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(vd_n) |-> (hcnt == '0 || hcnt == HW'(HALF)));

endmodule

bind vsync_gen vsync_gen_chk #(.H_TOTAL(H_TOTAL), .HALF(HALF)) u_chk (
    .clk(clk), .rst(rst), .hd_n(hd_n), .vd_n(vd_n), .blank(blank),
    .field(field), .fh2(fh2), .hcnt(hcnt), .h_reset(h_reset)
);

// File: tb/vsync_gen_bench.sv
module vsync_gen_bench;

    localparam int H = 40, HF = 20, NL = 25, HDL = 8, HB = 12, HS = 6;
    localparam int EQW = 3, VSW = 17, VDL = 3, VBL = 5, VDLY = 9, JIT = 2;

    logic clk = 0, rst = 1, hrst_n = 1, vrst_n = 1, direct_mode = 0, direct_hv = 0;
    logic hd_n, vd_n, csync_n, blank, field, fh2;

    vsync_gen #(
        .H_TOTAL(H), .HALF(HF), .LINES(NL), .HD_LOW(HDL), .HBLK(HB), .HSYNC(HS),
        .EQ_W(EQW), .VS_W(VSW), .VD_LINES(VDL), .VBLK_LINES(VBL),
        .V_DELAY(VDLY), .JITTER(JIT)
    ) u_vsync_gen (
        .clk(clk), .rst(rst), .hrst_n(hrst_n), .vrst_n(vrst_n),
        .direct_mode(direct_mode), .direct_hv(direct_hv),
        .hd_n(hd_n), .vd_n(vd_n), .csync_n(csync_n), .blank(blank),
        .field(field), .fh2(fh2)
    );

    always #2 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    int mhc = 0, mln = 0, mst = 0, mcnt = 0;
    bit mlock = 0, mpar = 0, mhp = 1, mvp = 1;
    int pend_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_out(input int hc, input int ln);
        int hl, r, ph, eqhl;
        bit fl, eq, vs, lo;
        hl   = 2 * ln + ((hc >= HF) ? 1 : 0);
        fl   = (hl >= NL);
        r    = fl ? hl - NL : hl;
        ph   = (hc >= HF) ? hc - HF : hc;
        eqhl = (2 * VDL) / 3;
        eq   = (r < eqhl) || (r >= 2 * eqhl && r < 3 * eqhl);
        vs   = (r >= eqhl) && (r < 2 * eqhl);
        lo   = eq ? (ph < EQW) : (vs ? (ph < VSW) : (hc < HS));
        return {hc >= HDL, r >= 2 * VDL, !lo, (hc < HB) || (r < 2 * VBL), fl, (hc == 0 || hc == HF)};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mhc = 0; mln = 0; mst = 0; mcnt = 0; mlock = 0; mpar = 0; mhp = 1; mvp = 1;
            pend_q.delete();
        end else begin
            bit hf, vf, doh, wr, md;
            int nom, d, nhc, nln;
            hf  = mhp && !hrst_n;
            vf  = mvp && !vrst_n;
            nom = (mhc + 1) % H;
            d   = (nom <= H / 2) ? nom : H - nom;
            if (direct_mode) doh = hf && direct_hv;
            else doh = hf && (!mlock || d > JIT);
            if (hf && !direct_mode) mlock = 1;
            nhc = doh ? 0 : nom;
            wr  = (nhc == 0);
            md  = (nhc == HF);
            nln = wr ? (mln + 1) % NL : mln;
            if (vf) begin
                mpar = (mhc >= HF);
                pend_q.delete();
                if (direct_mode && mpar) mst = 2;
                else begin
                    mst = 1;
                    pend_q.push_back(direct_mode ? 1 : VDLY);
                end
            end else if (mst == 1 && wr) begin
                mcnt = pend_q.pop_front() - 1;
                if (mcnt == 0) begin
                    if (mpar) mst = 2;
                    else begin nln = 0; mst = 0; end
                end else pend_q.push_back(mcnt);
            end else if (mst == 2 && md) begin
                nln = (NL - 1) / 2;
                mst = 0;
            end
            mhc = nhc; mln = nln; mhp = hrst_n; mvp = vrst_n;
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [5:0] e;
            e = ref_out(mhc, mln);
            chk(hd_n == e[5], "R1 hd_n", hd_n, e[5]);
            chk(vd_n == e[4], "R4 vd_n", vd_n, e[4]);
            chk(csync_n == e[3], "R3 csync_n", csync_n, e[3]);
            chk(blank == e[2], "R2 blank", blank, e[2]);
            chk(field == e[1], "R4 field", field, e[1]);
            chk(fh2 == e[0], "R5 fh2", fh2, e[0]);
        end
    end

    task automatic wait_pos(input int p);
        do @(negedge clk); while (mhc != p);
    endtask

    // pulse hrst_n low at position p, then check the next clock
    task automatic h_edge(input int p, input bit exp_fh2, input bit exp_hd, input string tag);
        wait_pos(p);
        hrst_n = 0;
        @(negedge clk);
        chk(fh2 == exp_fh2, {tag, " fh2 after H edge"}, fh2, exp_fh2);
        chk(hd_n == exp_hd, {tag, " hd_n after H edge"}, hd_n, exp_hd);
        repeat (2) @(negedge clk);
        hrst_n = 1;
    endtask

    // pulse vrst_n low at position p (optionally with hrst_n), check D clocks later
    task automatic v_edge(input int p, input int dly, input bit with_h, input bit exp_fld,
                          input bit exp_hd, input string tag);
        wait_pos(p);
        vrst_n = 0;
        if (with_h) hrst_n = 0;
        repeat (2) @(negedge clk);
        vrst_n = 1;
        hrst_n = 1;
        repeat (dly - 1) @(posedge clk);
        @(negedge clk);
        chk(vd_n == 1'b0, {tag, " vd_n at field start"}, vd_n, 0);
        chk(field == exp_fld, {tag, " field at field start"}, field, exp_fld);
        chk(hd_n == exp_hd, {tag, " hd_n at field start"}, hd_n, exp_hd);
        chk(fh2 == 1'b1, {tag, " fh2 at field start"}, fh2, 1);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 R2 R4 R5 reset state (checked while still in reset: decode of zeroed counters)
        chk(hd_n == 0, "R1 reset hd_n", hd_n, 0);
        chk(vd_n == 0, "R4 reset vd_n", vd_n, 0);
        chk(field == 0, "R4 reset field", field, 0);
        chk(blank == 1, "R2 reset blank", blank, 1);
        chk(fh2 == 1, "R5 reset fh2", fh2, 1);
        rst = 0;
        repeat (2100) @(negedge clk);

        // continuous mode horizontal resets
        h_edge(13, 1, 0, "R6 first edge");
        h_edge(38, 0, 1, "R7 within window");
        h_edge(1, 0, 0, "R7 distance 2 ignored");
        h_edge(2, 1, 0, "R7 distance 3 resets");
        repeat (50) @(negedge clk);

        // continuous mode vertical resets (R9 R10)
        v_edge(5, 39 - 5 + H * (VDLY - 1), 0, 0, 0, "R10 odd");
        repeat (300) @(negedge clk);
        v_edge(25, 39 - 25 + H * (VDLY - 1) + HF, 0, 1, 1, "R10 R9 even");
        repeat (300) @(negedge clk);

        // direct mode
        direct_mode = 1; direct_hv = 1;
        v_edge(10, 39 - 10, 0, 0, 0, "R11 odd");
        repeat (100) @(negedge clk);
        v_edge(30, 39 - 30 + HF, 0, 1, 1, "R11 R9 even");
        h_edge(30, 1, 0, "R8 hv edge");
        h_edge(1, 1, 0, "R8 hv no window");
        direct_hv = 0;
        h_edge(10, 0, 1, "R8 v-only ignored");
        repeat (60) @(negedge clk);

        // same-cycle H and V edges: classified on pre-reset position
        direct_hv = 1;
        v_edge(30, HF, 1, 1, 1, "R12 same cycle");
        repeat (100) @(negedge clk);

        // replacement of a pending start in continuous mode
        direct_mode = 0;
        wait_pos(5);
        vrst_n = 0;
        repeat (2) @(negedge clk);
        vrst_n = 1;
        repeat (3 * H) @(negedge clk);
        v_edge(25, 39 - 25 + H * (VDLY - 1) + HF, 0, 1, 1, "R12 replaced");
        repeat (2100) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule